// File: doc/BRIEF.md
# QoS-Aware Single-Grant Switching Controller

This block is the central switching controller of a multiport router with up to eight ports. Each port interface holds a head flit that needs a local route. It presents a routing request with a QoS level and an ordered list of candidate output ports. One shared input arbiter looks at all requests each cycle. A request takes part only if one of its candidate outputs is free. The arbiter picks the highest QoS level among these requests and breaks ties in round-robin order. It issues a single grant per cycle.

The granted output is reserved, and the crossbar select for that output points to the winning input from the next cycle. The reservation holds until the last flit of the packet is seen on that output. A port interface may also try to route a packet directly between neighbouring ports. That direct path raises a per-port claim, and this controller settles the conflict between the claim and a local grant. Route computation, flit storage, the crossbar datapath and the direct path itself are outside this block.

The request side follows valid/ready rules. A port interface raises `req_valid` and keeps its QoS level and candidate list stable until it sees `req_ready` high. The request is accepted in the cycle in which both are high. `req_ready` is never high for an input whose `req_valid` is low. Any number of requests may wait at the same time. The flit-observation, direct-claim and crossbar pins are plain control and status signals.

Top module: `qos_switch_ctrl`

## Requirements
- R1: At most one bit of `req_ready` is high in any cycle.
- R2: Among eligible requests, the grant goes to one with the largest QoS value. Value 0 is best effort and any non-zero value is guaranteed traffic.
- R3: Ties between equal QoS values go to the first eligible input at or after the round-robin pointer, counting upward and wrapping from 7 to 0. After a grant the pointer moves to the input just after the winner. With no grant it does not move.
- R4: A request is eligible only if at least one of its enabled candidate slots names a free output. An ineligible request is never granted and does not block a lower-QoS eligible request.
- R5: The reserved output is the first enabled, free candidate, in slot order 0, 1, 2. Slot k of input i occupies `req_cand[(i*3+k)*3 +: 3]` and is enabled by `req_cand_en[i*3+k]`.
- R6: In the cycle after a grant, `xbar_vld` is high for the reserved output, and that output's field `xbar_src[o*3 +: 3]` holds the winning input's index.
- R7: An output stays reserved until a flit with `out_flit_valid` high and type 2'b10 (tail) or 2'b11 (single-flit packet) is seen on it. It is free from the next cycle. Types 2'b00 (head) and 2'b01 (body) do not release it.
- R8: If a guaranteed-traffic direct claim (`dir_claim` and `dir_gt` high) is made on a port, that port is not free for best-effort requests in that cycle. A best-effort direct claim does not affect local arbitration. `dir_deny` is high for a claimed port that is reserved or granted locally in the same cycle.
- R9: After reset every output is free, `xbar_vld` is zero and the round-robin pointer is at input 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 8 | Per-input routing request valid |
| req_ready | output | 8 | Per-input grant; one-hot or zero |
| req_qos | input | 32 | 4-bit QoS level per input |
| req_cand | input | 72 | Three 3-bit candidate outputs per input, in preference order |
| req_cand_en | input | 24 | Enable per candidate slot |
| out_flit_valid | input | 8 | A flit is passing on this output |
| out_flit_type | input | 16 | 2-bit flit type per output |
| dir_claim | input | 8 | Direct path wants this output this cycle |
| dir_gt | input | 8 | That direct claim carries guaranteed traffic |
| dir_deny | output | 8 | Direct claim on this output loses to local routing |
| xbar_vld | output | 8 | Output is connected (reserved) |
| xbar_src | output | 24 | 3-bit input index feeding each output |

## Verification
Directed patterns come first. Two best-effort requests contend, which separates round-robin order from fixed index order. A best-effort and a guaranteed request contend, which separates QoS ordering from pointer order. A high-QoS request waits on a busy output, which shows that ineligible requests are skipped rather than blocking. Lists whose first slots are busy show that slot order is kept. Body versus tail flits separate holding from releasing. Guaranteed and best-effort direct claims show that only the former shadows a best-effort request. A long random run follows. It mixes QoS levels, sparse candidate lists, random flit types and claims. A behavioural reference model is compared every cycle, so it catches pointer drift and off-by-one-cycle reservation errors that the directed cases miss.

// File: rtl/qsc_pkg.sv
package qsc_pkg;
  typedef enum logic [1:0] {
    FK_HEAD = 2'b00,
    FK_BODY = 2'b01,
    FK_TAIL = 2'b10,
    FK_SOLO = 2'b11
  } flit_kind_e;

  function automatic logic ends_packet(flit_kind_e k);
    return (k == FK_TAIL) || (k == FK_SOLO);
  endfunction
endpackage

// File: rtl/qsc_elig.sv
module qsc_elig #(
  parameter int N_PORTS = 8,
  parameter int N_CAND  = 3,
  parameter int QOS_W   = 4,
  parameter int PW      = $clog2(N_PORTS)
) (
  input  logic [N_PORTS-1:0]           req_valid,
  input  logic [N_PORTS*QOS_W-1:0]     req_qos,
  input  logic [N_PORTS*N_CAND*PW-1:0] req_cand,
  input  logic [N_PORTS*N_CAND-1:0]    req_cand_en,
  input  logic [N_PORTS-1:0]           busy,
  input  logic [N_PORTS-1:0]           dir_claim,
  input  logic [N_PORTS-1:0]           dir_gt,
  output logic [N_PORTS-1:0]           elig,
  output logic [N_PORTS*PW-1:0]        pick
);
  for (genvar gi = 0; gi < N_PORTS; gi++) begin : g_in
    logic            is_be;
    logic            found;
    logic [PW-1:0]   port;

    assign is_be = (req_qos[gi*QOS_W +: QOS_W] == '0);

    always_comb begin
      found = 1'b0;
      port  = '0;
      // scan from the last slot so that the earliest usable slot wins
      for (int k = N_CAND - 1; k >= 0; k--) begin
        logic [PW-1:0] c;
        c = req_cand[(gi*N_CAND + k)*PW +: PW];
        if (req_cand_en[gi*N_CAND + k] && (int'(c) < N_PORTS) && !busy[c] &&
            !(dir_claim[c] && dir_gt[c] && is_be)) begin
          found = 1'b1;
          port  = c;
        end
      end
    end

    assign elig[gi]              = req_valid[gi] && found;
    assign pick[gi*PW +: PW]     = port;
  end
endmodule

// File: rtl/qsc_arb.sv
module qsc_arb #(
  parameter int N_PORTS = 8,
  parameter int QOS_W   = 4,
  parameter int PW      = $clog2(N_PORTS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_PORTS-1:0]       elig,
  input  logic [N_PORTS*QOS_W-1:0] req_qos,
  output logic [N_PORTS-1:0]       gnt,
  output logic                     gnt_any,
  output logic [PW-1:0]            gnt_idx
);
  logic [PW-1:0]    ptr;
  logic [QOS_W-1:0] top_q;
  logic [QOS_W-1:0] win_q;

  always_comb begin
    top_q = '0;
    for (int i = 0; i < N_PORTS; i++)
      if (elig[i] && (req_qos[i*QOS_W +: QOS_W] > top_q))
        top_q = req_qos[i*QOS_W +: QOS_W];
  end

  always_comb begin
    gnt_any = 1'b0;
    gnt_idx = '0;
    for (int j = N_PORTS - 1; j >= 0; j--) begin
      int idx;
      idx = (int'(ptr) + j) % N_PORTS;
      if (elig[idx] && (req_qos[idx*QOS_W +: QOS_W] == top_q)) begin
        gnt_any = 1'b1;
        gnt_idx = PW'(idx);
      end
    end
  end

  assign gnt   = gnt_any ? (N_PORTS'(1) << gnt_idx) : '0;
  assign win_q = req_qos[gnt_idx*QOS_W +: QOS_W];

  always_ff @(posedge clk) begin
    if (!rst_n)
      ptr <= '0;
    else if (gnt_any)
      ptr <= (int'(gnt_idx) == N_PORTS - 1) ? '0 : gnt_idx + PW'(1);
  end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt)); // R1
  AST_GNT_ELIG: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_any |-> elig[gnt_idx]); // R4
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !gnt_any |=> $stable(ptr)); // R3

  for (genvar gi = 0; gi < N_PORTS; gi++) begin : g_chk
    AST_QOS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_any && elig[gi]) |-> (req_qos[gi*QOS_W +: QOS_W] <= win_q)); // R2
  end
endmodule

// File: rtl/qsc_outstate.sv
module qsc_outstate #(
  parameter int N_PORTS = 8,
  parameter int PW      = $clog2(N_PORTS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  set_vld,
  input  logic [PW-1:0]         set_port,
  input  logic [PW-1:0]         set_src,
  input  logic [N_PORTS-1:0]    rel,
  output logic [N_PORTS-1:0]    busy,
  output logic [N_PORTS*PW-1:0] src
);
  for (genvar go = 0; go < N_PORTS; go++) begin : g_out
    logic hit;
    assign hit = set_vld && (set_port == PW'(go));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        busy[go]          <= 1'b0;
        src[go*PW +: PW]  <= '0;
      end else if (hit) begin
        busy[go]          <= 1'b1;
        src[go*PW +: PW]  <= set_src;
      end else if (rel[go]) begin
        busy[go]          <= 1'b0;
      end
    end

    AST_SET_ON_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> !busy[go]); // R4
    AST_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (busy[go] && !rel[go]) |=> busy[go]); // R7
    AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (busy[go] && rel[go]) |=> !busy[go]); // R7
  end
endmodule

// File: rtl/qos_switch_ctrl.sv
module qos_switch_ctrl #(
  parameter int N_PORTS = 8,
  parameter int N_CAND  = 3,
  parameter int QOS_W   = 4,
  parameter int PW      = $clog2(N_PORTS)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [N_PORTS-1:0]             req_valid,
  output logic [N_PORTS-1:0]             req_ready,
  input  logic [N_PORTS*QOS_W-1:0]       req_qos,
  input  logic [N_PORTS*N_CAND*PW-1:0]   req_cand,
  input  logic [N_PORTS*N_CAND-1:0]      req_cand_en,
  input  logic [N_PORTS-1:0]             out_flit_valid,
  input  logic [N_PORTS*2-1:0]           out_flit_type,
  input  logic [N_PORTS-1:0]             dir_claim,
  input  logic [N_PORTS-1:0]             dir_gt,
  output logic [N_PORTS-1:0]             dir_deny,
  output logic [N_PORTS-1:0]             xbar_vld,
  output logic [N_PORTS*PW-1:0]          xbar_src
);
  logic [N_PORTS-1:0]      elig;
  logic [N_PORTS-1:0]      busy;
  logic [N_PORTS-1:0]      rel;
  logic [N_PORTS*PW-1:0]   pick;
  logic                    gnt_any;
  logic [PW-1:0]           gnt_idx;
  logic [PW-1:0]           gnt_port;
  logic [QOS_W-1:0]        win_qos;

  qsc_elig #(.N_PORTS(N_PORTS), .N_CAND(N_CAND), .QOS_W(QOS_W), .PW(PW)) u_elig (
    .req_valid(req_valid), .req_qos(req_qos), .req_cand(req_cand),
    .req_cand_en(req_cand_en), .busy(busy), .dir_claim(dir_claim),
    .dir_gt(dir_gt), .elig(elig), .pick(pick)
  );

  qsc_arb #(.N_PORTS(N_PORTS), .QOS_W(QOS_W), .PW(PW)) u_arb (
    .clk(clk), .rst_n(rst_n), .elig(elig), .req_qos(req_qos),
    .gnt(req_ready), .gnt_any(gnt_any), .gnt_idx(gnt_idx)
  );

  assign gnt_port = pick[gnt_idx*PW +: PW];
  assign win_qos  = req_qos[gnt_idx*QOS_W +: QOS_W];

  for (genvar go = 0; go < N_PORTS; go++) begin : g_port
    assign rel[go] = out_flit_valid[go] &&
                     qsc_pkg::ends_packet(qsc_pkg::flit_kind_e'(out_flit_type[go*2 +: 2]));
    assign dir_deny[go] = dir_claim[go] &&
                          (busy[go] || (gnt_any && (gnt_port == PW'(go))));

    AST_XBAR_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_any && (gnt_port == PW'(go))) |=>
        (xbar_vld[go] && (xbar_src[go*PW +: PW] == $past(gnt_idx)))); // R6
    AST_GT_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_claim[go] && dir_gt[go] && gnt_any && (gnt_port == PW'(go)))
        |-> (win_qos != '0)); // R8
  end

  qsc_outstate #(.N_PORTS(N_PORTS), .PW(PW)) u_out (
    .clk(clk), .rst_n(rst_n), .set_vld(gnt_any), .set_port(gnt_port),
    .set_src(gnt_idx), .rel(rel), .busy(busy), .src(xbar_src)
  );

  assign xbar_vld = busy;
endmodule

// File: tb/tb_qos_switch_ctrl.sv
module tb_qos_switch_ctrl;
  localparam int N = 8;
  localparam int K = 3;
  localparam int QW = 4;
  localparam int PW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]      req_valid = '0;
  logic [N-1:0]      req_ready;
  logic [N*QW-1:0]   req_qos = '0;
  logic [N*K*PW-1:0] req_cand = '0;
  logic [N*K-1:0]    req_cand_en = '0;
  logic [N-1:0]      out_flit_valid = '0;
  logic [N*2-1:0]    out_flit_type = '0;
  logic [N-1:0]      dir_claim = '0;
  logic [N-1:0]      dir_gt = '0;
  logic [N-1:0]      dir_deny;
  logic [N-1:0]      xbar_vld;
  logic [N*PW-1:0]   xbar_src;

  always #10 clk = ~clk;

  qos_switch_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_qos(req_qos), .req_cand(req_cand), .req_cand_en(req_cand_en),
    .out_flit_valid(out_flit_valid), .out_flit_type(out_flit_type),
    .dir_claim(dir_claim), .dir_gt(dir_gt), .dir_deny(dir_deny),
    .xbar_vld(xbar_vld), .xbar_src(xbar_src)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit busy_m [N];
  int src_m  [N];
  int ptr_m  = 0;

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  task automatic set_req(int i, int q, int c0, int c1, int c2);
    int cs [3];
    cs[0] = c0; cs[1] = c1; cs[2] = c2;
    req_valid[i] = 1'b1;
    req_qos[i*QW +: QW] = QW'(q);
    for (int k = 0; k < K; k++) begin
      req_cand_en[i*K + k] = (cs[k] >= 0);
      req_cand[(i*K + k)*PW +: PW] = (cs[k] >= 0) ? PW'(cs[k]) : '0;
    end
  endtask

  // one clock of the reference model, compared at mid-cycle
  task automatic step();
    bit el [N];
    int pp [N];
    int maxq, win, wport;
    logic [N-1:0] exp_rdy, exp_deny, exp_vld;
    #2;
    for (int i = 0; i < N; i++) begin
      int q;
      q = int'(req_qos[i*QW +: QW]);
      el[i] = 1'b0; pp[i] = 0;
      for (int k = 0; k < K; k++) begin
        int c;
        c = int'(req_cand[(i*K + k)*PW +: PW]);
        if (!el[i] && req_cand_en[i*K + k] && !busy_m[c] &&
            !(dir_claim[c] && dir_gt[c] && q == 0)) begin
          el[i] = 1'b1; pp[i] = c;
        end
      end
      el[i] = el[i] && req_valid[i];
    end
    maxq = -1;
    for (int i = 0; i < N; i++)
      if (el[i] && int'(req_qos[i*QW +: QW]) > maxq) maxq = int'(req_qos[i*QW +: QW]);
    win = -1;
    for (int j = 0; j < N; j++) begin
      int idx;
      idx = (ptr_m + j) % N;
      if (win < 0 && el[idx] && int'(req_qos[idx*QW +: QW]) == maxq) win = idx;
    end
    wport = (win >= 0) ? pp[win] : -1;
    exp_rdy = (win >= 0) ? (N'(1) << win) : '0;
    for (int o = 0; o < N; o++) begin
      exp_deny[o] = dir_claim[o] && (busy_m[o] || wport == o);
      exp_vld[o]  = busy_m[o];
    end
    chk($countones(req_ready) <= 1, "R1", "grant count", $countones(req_ready), 1);
    chk(req_ready == exp_rdy, "R2", "req_ready", req_ready, exp_rdy);
    chk(dir_deny == exp_deny, "R8", "dir_deny", dir_deny, exp_deny);
    chk(xbar_vld == exp_vld, "R7", "xbar_vld", xbar_vld, exp_vld);
    for (int o = 0; o < N; o++)
      if (busy_m[o])
        chk(int'(xbar_src[o*PW +: PW]) == src_m[o], "R6", "xbar_src",
            xbar_src[o*PW +: PW], src_m[o]);
    @(posedge clk);
    for (int o = 0; o < N; o++)
      if (out_flit_valid[o] && out_flit_type[o*2 + 1]) busy_m[o] = 1'b0;
    if (win >= 0) begin
      busy_m[wport] = 1'b1;
      src_m[wport]  = win;
      ptr_m = (win + 1) % N;
    end
    @(negedge clk);
    if (win >= 0) req_valid[win] = 1'b0;
    out_flit_valid = '0;
    dir_claim = '0;
    dir_gt = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    for (int o = 0; o < N; o++) begin busy_m[o] = 1'b0; src_m[o] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk(xbar_vld == '0, "R9", "xbar_vld after reset", xbar_vld, 0);
    chk(req_ready == '0, "R9", "req_ready idle", req_ready, 0);
    step();

    // R3: tie between two best-effort requests, pointer at 0
    set_req(1, 0, 2, -1, -1);
    set_req(5, 0, 4, -1, -1);
    #2 chk(req_ready == 8'h02, "R3", "first tie winner", req_ready, 8'h02);
    step();
    #2 chk(req_ready == 8'h20, "R3", "second tie winner", req_ready, 8'h20);
    chk(xbar_vld[2] && xbar_src[6 +: 3] == 3'd1, "R6", "port2 connect", xbar_src[6 +: 3], 1);
    step();

    // R2: guaranteed beats best effort
    set_req(0, 0, 3, -1, -1);
    set_req(6, 5, 5, -1, -1);
    #2 chk(req_ready == 8'h40, "R2", "GT over BE", req_ready, 8'h40);
    step();
    step();

    // R4: high-QoS request on a busy output does not block
    set_req(2, 9, 3, -1, -1);
    set_req(4, 0, 6, -1, -1);
    #2 chk(req_ready == 8'h10, "R4", "skip ineligible", req_ready, 8'h10);
    step();

    // R5: first free candidate in slot order
    set_req(7, 0, 3, 5, 0);
    step();
    #2 chk(xbar_vld[0] && xbar_src[0 +: 3] == 3'd7, "R5", "slot order port0", xbar_src[0 +: 3], 7);

    // R7: body holds, tail releases
    out_flit_valid[3] = 1'b1; out_flit_type[6 +: 2] = 2'b01;
    step();
    #2 chk(xbar_vld[3] == 1'b1, "R7", "held after body", xbar_vld[3], 1);
    out_flit_valid[3] = 1'b1; out_flit_type[6 +: 2] = 2'b10;
    step();
    #2 chk(xbar_vld[3] == 1'b0, "R7", "free after tail", xbar_vld[3], 0);
    chk(req_ready == 8'h04, "R4", "waiter now eligible", req_ready, 8'h04);
    step();

    // R8: GT direct claim shadows BE request; BE claim does not
    dir_claim[1] = 1'b1; dir_gt[1] = 1'b1;
    set_req(3, 0, 1, -1, -1);
    #2 chk(req_ready == 8'h00, "R8", "BE shadowed", req_ready, 0);
    chk(dir_deny[1] == 1'b0, "R8", "GT direct kept", dir_deny[1], 0);
    step();
    dir_claim[1] = 1'b1; dir_gt[1] = 1'b0;
    #2 chk(req_ready == 8'h08, "R8", "local beats BE direct", req_ready, 8'h08);
    chk(dir_deny[1] == 1'b1, "R8", "BE direct denied", dir_deny[1], 1);
    step();

    out_flit_valid = '1; out_flit_type = '1;
    step();

    for (int cyc = 0; cyc < 4000; cyc++) begin
      for (int i = 0; i < N; i++) begin
        if (!req_valid[i] && ($urandom % 3 == 0)) begin
          int q;
          q = ($urandom % 4 == 0) ? 1 + int'($urandom % 15) : 0;
          req_valid[i] = 1'b1;
          req_qos[i*QW +: QW] = QW'(q);
          for (int k = 0; k < K; k++) begin
            req_cand_en[i*K + k] = ($urandom % 4 != 0);
            req_cand[(i*K + k)*PW +: PW] = PW'($urandom % N);
          end
          if (req_cand_en[i*K +: K] == '0) req_cand_en[i*K + 2] = 1'b1;
        end
      end
      for (int o = 0; o < N; o++) begin
        if ($urandom % 5 == 0) begin
          out_flit_valid[o] = 1'b1;
          out_flit_type[o*2 +: 2] = 2'($urandom % 4);
        end
        if ($urandom % 8 == 0) begin
          dir_claim[o] = 1'b1;
          dir_gt[o] = 1'($urandom % 2);
        end
      end
      step();
    end

    summary();
    $finish;
  end
endmodule